// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called A and B, through tri-state drivers in both directions. Each direction has its own capture register, its own output enable and its own source select. A direction can forward the live level of the opposite bus, or it can drive the value its register last captured. Registers capture on the rising edge of their own capture clock, whatever the enables and selects are doing. A bus can therefore be sampled while the block is not driving it, and the sample can be replayed later.

The data path is built from parameterised lanes, by default two lanes of eight bits. Each lane has a complete, independent set of capture clocks, enables and selects. Tying the per-lane controls together makes one wide transceiver.

When both directions of a lane are enabled and both forward live data, the two buses would feed each other. The block models this hold loop with a per-bit keeper register, clocked by `clk`, that freezes the last value the lane resolved. Both buses then carry that value with no combinational oscillation. A `pwr_ok` input forces every bus driver off. A synchronous `clr` zeroes the capture registers on their capture edges and the keeper on `clk`.

Top module: `bus_xcvr`

## Requirements
- R1: Lane k owns bits [8k+7:8k] of both buses. Its clocks, enables and selects have no effect on any other lane's bus bits or registers.
- R2: The lane drives its slice of bus B only when pwr_ok is 1 and its A-to-B enable `en_ab` is 1 (active high). Otherwise B carries whatever an external source drives.
- R3: The lane drives its slice of bus A only when pwr_ok is 1 and its B-to-A enable `en_ba_n` is 0 (active low). Otherwise A carries whatever an external source drives.
- R4: A select value of 0 makes that direction forward the live level of the opposite bus. A value of 1 makes it drive that direction's capture register: `sel_ab` picks the A-to-B register, and `sel_ba` picks the B-to-A register.
- R5: A rising edge on `cap_ab[k]` stores the lane's A slice, and a rising edge on `cap_ba[k]` stores the lane's B slice. Both captures happen with enables and selects at any level, including while the outputs are disabled.
- R6: With both directions of a lane enabled and both selects at 0, no external source is allowed on that lane. Both buses then hold the value the lane carried on the last `clk` edge before the loop closed, and the two buses stay equal.
- R7: Toggling a select while the live value equals the stored value leaves the driven bus unchanged at every instant.
- R8: While pwr_ok is 0, no lane drives bus A or bus B, whatever the control inputs are.
- R9: A capture edge with `clr` at 1 loads zero into that register. A `clk` edge with `clr` at 1 loads zero into the keeper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Keeper sample clock |
| clr | input | 1 | Synchronous clear, active high |
| pwr_ok | input | 1 | Supply good; 0 turns all drivers off |
| en_ab | input | LANES | A-to-B output enable per lane, active high |
| en_ba_n | input | LANES | B-to-A output enable per lane, active low |
| sel_ab | input | LANES | A-to-B source: 0 live A, 1 register |
| sel_ba | input | LANES | B-to-A source: 0 live B, 1 register |
| cap_ab | input | LANES | A-to-B capture clock per lane |
| cap_ba | input | LANES | B-to-A capture clock per lane |
| a_bus | inout | LANES*LANE_W | Bus A |
| b_bus | inout | LANES*LANE_W | Bus B |

## Verification
The assertions assume that nothing outside the block drives a bus slice while the block drives that slice. Under that assumption the resolved bus equals the block's own value, so stored-mode and loop-mode checks compare bus levels with register contents. The bench enables its own tri-state driver on a slice only where the control vector leaves that slice undriven by the block, and it switches both sides in the same time step. It also lets the lane forward live A for several `clk` cycles before closing any hold loop, so the keeper has a defined value when the loop closes.

// File: rtl/bus_xcvr_pkg.sv
`timescale 1ns/1ps
package bus_xcvr_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } xcvr_src_e;

   function automatic int lane_lo(input int lane, input int lane_w);
      return lane * lane_w;
   endfunction
endpackage

// File: rtl/bus_xcvr_capreg.sv
`timescale 1ns/1ps
module bus_xcvr_capreg #(
   parameter int W         = 8,
   parameter bit HAS_CLEAR = 1'b1
) (
   input  logic         cap_clk,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (HAS_CLEAR) begin : g_clr
         always_ff @(posedge cap_clk) begin
            if (clr) q <= '0;
            else     q <= d;
         end
      end else begin : g_noclr
         always_ff @(posedge cap_clk) q <= d;
      end
   endgenerate

   // R5: contents at the next capture edge are what was sampled at this one
   p_capture_r5: assert property (@(posedge cap_clk) disable iff (clr)
      !clr |=> q == $past(d));
endmodule

// File: rtl/bus_xcvr_keeper.sv
`timescale 1ns/1ps
module bus_xcvr_keeper #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (clr)        q <= '0;
      else if (!hold) q <= d;
   end

   // R6: a closed loop freezes every keeper bit
   p_keep_hold_r6: assert property (@(posedge clk) disable iff (clr)
      hold |=> $stable(q));
endmodule

// File: rtl/bus_xcvr_lane.sv
`timescale 1ns/1ps
module bus_xcvr_lane
   import bus_xcvr_pkg::*;
#(
   parameter int W         = 8,
   parameter bit HAS_CLEAR = 1'b1
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         pwr_ok,
   input  logic         en_ab,
   input  logic         en_ba_n,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic         cap_ab,
   input  logic         cap_ba,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_val,
   output logic         a_oe,
   output logic [W-1:0] b_val,
   output logic         b_oe
);
   logic [W-1:0] ab_q, ba_q, keep_q, keep_d;
   logic         loop_closed;
   xcvr_src_e    src_ab, src_ba;

   assign src_ab = xcvr_src_e'(sel_ab);
   assign src_ba = xcvr_src_e'(sel_ba);

   // R2 R3 R8: enables gated by supply
   assign b_oe = pwr_ok & en_ab;
   assign a_oe = pwr_ok & ~en_ba_n;

   assign loop_closed = a_oe & b_oe & (src_ab == SRC_LIVE) & (src_ba == SRC_LIVE);

   // R5: captures independent of enables and selects
   bus_xcvr_capreg #(.W(W), .HAS_CLEAR(HAS_CLEAR)) u_reg_ab (
      .cap_clk(cap_ab), .clr(clr), .d(a_in), .q(ab_q));
   bus_xcvr_capreg #(.W(W), .HAS_CLEAR(HAS_CLEAR)) u_reg_ba (
      .cap_clk(cap_ba), .clr(clr), .d(b_in), .q(ba_q));

   // R4 R7: single-level source choice; the opposite side's own value is used
   // when this lane drives it, so the block never reads back its own driver
   always_comb begin
      if (src_ba == SRC_STORED)      a_val = ba_q;
      else if (!b_oe)                a_val = b_in;
      else if (src_ab == SRC_STORED) a_val = ab_q;
      else                           a_val = keep_q;

      if (src_ab == SRC_STORED)      b_val = ab_q;
      else if (!a_oe)                b_val = a_in;
      else if (src_ba == SRC_STORED) b_val = ba_q;
      else                           b_val = keep_q;
   end

   // R6: keeper tracks the value the lane resolves while the loop is open
   always_comb begin
      if (b_oe)      keep_d = b_val;
      else if (a_oe) keep_d = a_val;
      else           keep_d = a_in;
   end

   bus_xcvr_keeper #(.W(W)) u_keep (
      .clk(clk), .clr(clr), .hold(loop_closed), .d(keep_d), .q(keep_q));

   // R4: stored mode puts the register on the resolved bus
   p_b_stored_r4: assert property (@(posedge clk) disable iff (clr)
      (b_oe && src_ab == SRC_STORED) |-> b_in == ab_q);
   p_a_stored_r4: assert property (@(posedge clk) disable iff (clr)
      (a_oe && src_ba == SRC_STORED) |-> a_in == ba_q);
   // R6: both buses agree while the loop is closed
   p_loop_equal_r6: assert property (@(posedge clk) disable iff (clr)
      loop_closed |-> a_in == b_in);
endmodule

// File: rtl/bus_xcvr.sv
`timescale 1ns/1ps
module bus_xcvr
   import bus_xcvr_pkg::*;
#(
   parameter int LANES     = 2,
   parameter int LANE_W    = 8,
   parameter bit HAS_CLEAR = 1'b1
) (
   input  logic                     clk,
   input  logic                     clr,
   input  logic                     pwr_ok,
   input  logic [LANES-1:0]         en_ab,
   input  logic [LANES-1:0]         en_ba_n,
   input  logic [LANES-1:0]         sel_ab,
   input  logic [LANES-1:0]         sel_ba,
   input  logic [LANES-1:0]         cap_ab,
   input  logic [LANES-1:0]         cap_ba,
   inout  wire  [LANES*LANE_W-1:0]  a_bus,
   inout  wire  [LANES*LANE_W-1:0]  b_bus
);
   localparam int BUS_W = LANES * LANE_W;

   if (LANES < 1)  begin : g_bad_lanes $error("bus_xcvr: LANES must be at least 1"); end
   if (LANE_W < 1) begin : g_bad_width $error("bus_xcvr: LANE_W must be at least 1"); end

   logic [LANES-1:0] a_oe_v, b_oe_v;

   // R1: one independent lane per slice
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int LO = lane_lo(k, LANE_W);
      logic [LANE_W-1:0] a_val, b_val;

      bus_xcvr_lane #(.W(LANE_W), .HAS_CLEAR(HAS_CLEAR)) u_lane (
         .clk(clk), .clr(clr), .pwr_ok(pwr_ok),
         .en_ab(en_ab[k]), .en_ba_n(en_ba_n[k]),
         .sel_ab(sel_ab[k]), .sel_ba(sel_ba[k]),
         .cap_ab(cap_ab[k]), .cap_ba(cap_ba[k]),
         .a_in(a_bus[LO +: LANE_W]), .b_in(b_bus[LO +: LANE_W]),
         .a_val(a_val), .a_oe(a_oe_v[k]),
         .b_val(b_val), .b_oe(b_oe_v[k]));

      assign a_bus[LO +: LANE_W] = a_oe_v[k] ? a_val : {LANE_W{1'bz}};
      assign b_bus[LO +: LANE_W] = b_oe_v[k] ? b_val : {LANE_W{1'bz}};

      // R2: supply good and enable high means this lane drives B
      p_b_drive_r2: assert property (@(posedge clk) disable iff (clr)
         (pwr_ok && en_ab[k]) |-> b_oe_v[k]);
      // R3: supply good and active-low enable low means this lane drives A
      p_a_drive_r3: assert property (@(posedge clk) disable iff (clr)
         (pwr_ok && !en_ba_n[k]) |-> a_oe_v[k]);
   end

   // R8: supply loss releases every driver
   p_power_off_r8: assert property (@(posedge clk) disable iff (clr)
      !pwr_ok |-> (a_oe_v == '0 && b_oe_v == '0));

   logic [BUS_W-1:0] unused_w;
   assign unused_w = '0;
endmodule

// File: tb/sim_bus_xcvr.sv
`timescale 1ns/1ps
module sim_bus_xcvr;
   localparam int LANES = 2;
   localparam int LW    = 8;
   localparam int MAXC  = 200000;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             clr = 1'b1, pwr_ok = 1'b1;
   logic [LANES-1:0] en_ab = '0, en_ba_n = '1, sel_ab = '0, sel_ba = '0;
   logic [LANES-1:0] cap_ab = '0, cap_ba = '0;
   logic [LANES-1:0] a_ext_en = '0, b_ext_en = '0;
   logic [15:0]      a_ext = '0, b_ext = '0;
   wire  [15:0]      a_bus, b_bus;

   for (genvar k = 0; k < LANES; k++) begin : g_ext
      assign a_bus[k*LW +: LW] = a_ext_en[k] ? a_ext[k*LW +: LW] : {LW{1'bz}};
      assign b_bus[k*LW +: LW] = b_ext_en[k] ? b_ext[k*LW +: LW] : {LW{1'bz}};
   end

   bus_xcvr #(.LANES(LANES), .LANE_W(LW), .HAS_CLEAR(1'b1)) u0 (
      .clk(clk), .clr(clr), .pwr_ok(pwr_ok),
      .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .cap_ab(cap_ab), .cap_ba(cap_ba), .a_bus(a_bus), .b_bus(b_bus));

   int total = 0, bad = 0;
   bit done = 1'b0;

   // per-lane data: live A, live B, A-to-B register, B-to-A register
   localparam logic [7:0] PA [2] = '{8'h3C, 8'hC3};
   localparam logic [7:0] PB [2] = '{8'hA5, 8'h5A};
   localparam logic [7:0] RA [2] = '{8'h96, 8'h69};
   localparam logic [7:0] RB [2] = '{8'h0F, 8'hF0};

   // {en_ab, en_ba_n, sel_ab, sel_ba, expected A source, expected B source}
   // source codes: 0 live A pattern, 1 live B pattern, 2 A-to-B reg, 3 B-to-A reg
   localparam logic [7:0] TBL [16] = '{
      {4'd0,  2'd1, 2'd1}, {4'd1,  2'd3, 2'd1}, {4'd2,  2'd1, 2'd1}, {4'd3,  2'd3, 2'd1},
      {4'd4,  2'd0, 2'd1}, {4'd5,  2'd0, 2'd1}, {4'd6,  2'd0, 2'd1}, {4'd7,  2'd0, 2'd1},
      {4'd8,  2'd0, 2'd0}, {4'd9,  2'd3, 2'd3}, {4'd10, 2'd2, 2'd2}, {4'd11, 2'd3, 2'd2},
      {4'd12, 2'd0, 2'd0}, {4'd13, 2'd0, 2'd0}, {4'd14, 2'd0, 2'd2}, {4'd15, 2'd0, 2'd2}
   };

   function automatic logic [7:0] src_val(input logic [1:0] code, input int lane);
      case (code)
         2'd0:    return PA[lane];
         2'd1:    return PB[lane];
         2'd2:    return RA[lane];
         default: return RB[lane];
      endcase
   endfunction

   task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req, input string what);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic [LANES-1:0] ab, input logic [LANES-1:0] ba);
      #0.5 cap_ab = ab; cap_ba = ba;
      #0.5 cap_ab = '0; cap_ba = '0;
   endtask

   initial begin
      #(MAXC * 4);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R9: clear during capture edges and clk edges
      wait_clk(3);
      pulse('1, '1);
      wait_clk(1);
      clr = 1'b0;
      wait_clk(1);
      en_ab = '1; sel_ab = '1; en_ba_n = '0; sel_ba = '1;
      wait_clk(1);
      for (int k = 0; k < LANES; k++) begin
         check(b_bus[k*LW +: LW], 8'h00, "R9", "cleared A-to-B register");
         check(a_bus[k*LW +: LW], 8'h00, "R9", "cleared B-to-A register");
      end

      // R5: load registers while all outputs are disabled
      en_ab = '0; en_ba_n = '1; sel_ab = '0; sel_ba = '0;
      a_ext = {RA[1], RA[0]}; b_ext = {RB[1], RB[0]};
      a_ext_en = '1; b_ext_en = '1;
      wait_clk(1);
      pulse('1, '1);
      a_ext = {PA[1], PA[0]}; b_ext = {PB[1], PB[0]};
      wait_clk(1);
      for (int k = 0; k < LANES; k++) begin
         check(a_bus[k*LW +: LW], PA[k], "R3", "A undriven with outputs off");
         check(b_bus[k*LW +: LW], PB[k], "R2", "B undriven with outputs off");
      end

      // table walk: lane 0 takes entry i, lane 1 takes entry 15-i (R1)
      for (int i = 0; i < 16; i++) begin
         logic [7:0] e [2];
         e[0] = TBL[i]; e[1] = TBL[15-i];
         // pre-phase: forward live A so the keeper holds PA
         en_ab = '1; en_ba_n = '1; sel_ab = '0; sel_ba = '0;
         a_ext = {PA[1], PA[0]}; b_ext = {PB[1], PB[0]};
         a_ext_en = '1; b_ext_en = '0;
         wait_clk(3);
         for (int k = 0; k < LANES; k++) begin
            en_ab[k]    = e[k][7];
            en_ba_n[k]  = e[k][6];
            sel_ab[k]   = e[k][5];
            sel_ba[k]   = e[k][4];
            a_ext_en[k] = e[k][6];
            b_ext_en[k] = ~e[k][7];
         end
         wait_clk(2);
         for (int k = 0; k < LANES; k++) begin
            string req;
            if (e[k][7] && !e[k][6] && !e[k][5] && !e[k][4]) req = "R6";
            else if (e[k][5] || e[k][4])                     req = "R4";
            else                                             req = "R2 R3";
            check(a_bus[k*LW +: LW], src_val(e[k][3:2], k), req, $sformatf("table %0d lane %0d bus A", i, k));
            check(b_bus[k*LW +: LW], src_val(e[k][1:0], k), req, $sformatf("table %0d lane %0d bus B", i, k));
         end
         // R6: loop keeps holding after further clk edges
         if (e[0][7:4] == 4'b1000) begin
            wait_clk(4);
            check(a_bus[7:0], PA[0], "R6", "loop hold later A");
            check(b_bus[7:0], PA[0], "R6", "loop hold later B");
         end
      end

      // R8: supply loss with every lane asking to drive stored data
      en_ab = '1; en_ba_n = '0; sel_ab = '1; sel_ba = '1;
      a_ext_en = '0; b_ext_en = '0;
      wait_clk(1);
      pwr_ok = 1'b0;
      a_ext = 16'h1E2D; b_ext = 16'h4B78;
      a_ext_en = '1; b_ext_en = '1;
      wait_clk(2);
      check(a_bus[7:0],  8'h2D, "R8", "A lane 0 released");
      check(a_bus[15:8], 8'h1E, "R8", "A lane 1 released");
      check(b_bus[7:0],  8'h78, "R8", "B lane 0 released");
      check(b_bus[15:8], 8'h4B, "R8", "B lane 1 released");
      a_ext_en = '0; b_ext_en = '0;
      pwr_ok = 1'b1;

      // R5 R1: capture lane 0 only while its B output shows the register
      en_ab = '1; en_ba_n = '1; sel_ab = '1; sel_ba = '0;
      a_ext = {8'h11, 8'h77}; a_ext_en = '1;
      wait_clk(1);
      pulse(2'b01, 2'b00);
      wait_clk(1);
      check(b_bus[7:0],  8'h77, "R5", "lane 0 captured while driving");
      check(b_bus[15:8], RA[1], "R1", "lane 1 register untouched");

      // R5: B-to-A capture while that direction is disabled
      en_ab = '0; b_ext = {8'h22, 8'h88}; b_ext_en = '1;
      wait_clk(1);
      pulse(2'b00, 2'b11);
      b_ext_en = '0; a_ext_en = '0;
      en_ba_n = '0; sel_ba = '1; en_ab = '0;
      b_ext = 16'h0000; b_ext_en = '1;
      wait_clk(1);
      check(a_bus[7:0],  8'h88, "R5", "lane 0 B-to-A captured while off");
      check(a_bus[15:8], 8'h22, "R5", "lane 1 B-to-A captured while off");

      // R7: toggle select with live A equal to stored value
      en_ba_n = '1; sel_ba = '0; b_ext_en = '0;
      a_ext = {8'h11, 8'h77}; a_ext_en = '1;
      en_ab = 2'b01; sel_ab = 2'b00;
      wait_clk(1);
      for (int t = 0; t < 4; t++) begin
         sel_ab[0] = ~sel_ab[0];
         for (int s = 0; s < 3; s++) begin
            #0.3;
            check(b_bus[7:0], 8'h77, "R7", "select change on B");
         end
         wait_clk(1);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule